// File: doc/BRIEF.md
# Trace Commit Gate with Pending-Verify Tags

This block sits beside the commit stage of a processor pipeline and holds back retirement of instructions that belong to a code trace whose integrity check is still running. When fetch enters a monitored trace, the gate hands out one of a small pool of trace slots. Every instruction of that trace then travels down the pipeline with a pending tag and the slot number. When the instruction reaches the head of commit, the gate looks at the slot and releases the instruction only once the check for that slot has come back as a pass.

Check results arrive per slot as pass or fail. A pass lets the trace's tagged instructions retire. The slot is freed when the instruction flagged as the trace's last one commits. A fail raises an interrupt and blocks the slot's instructions permanently, until a flush for that slot returns it to the pool. Untagged instructions, which belong to no monitored trace, are never held. When a new trace finds every slot busy, the gate stalls fetch.

Top module: `trace_commit_gate`

## Requirements
- R1: After reset all four slots are free: `alloc_ok_o` follows `trace_start_i`, `fetch_stall_o` is 0, `irq_o` is 0, and `commit_o` and `stall_o` are 0 while `head_valid_i` is 0.
- R2: A valid head with `head_tag_i`=0 commits in the same cycle (`commit_o`=1, `stall_o`=0), whatever the state of the slots.
- R3: A valid head with `head_tag_i`=1 whose slot (`head_slot_i`, 2 bits, slot 0..3) is pending, failed or free gives `stall_o`=1 and `commit_o`=0.
- R4: A pass result (`vres_valid_i`=1, `vres_pass_i`=1) for a pending slot lets tagged heads of that slot commit, starting in the same cycle as the result.
- R5: A fail result (`vres_pass_i`=0) for a pending slot drives `irq_o` high for exactly the following cycle. From the cycle of the result on, tagged heads of that slot stall until the slot is flushed.
- R6: `flush_i` with `flush_slot_i` frees that slot from the next cycle only if the slot is failed; a flush of a slot in any other state has no effect.
- R7: When `trace_start_i` is 1 and a slot is free, `alloc_ok_o`=1 and `alloc_slot_o` gives the lowest-numbered free slot, which is pending from the next cycle.
- R8: When `trace_start_i` is 1 and no slot is free, `fetch_stall_o`=1 and `alloc_ok_o`=0, and no slot changes state.
- R9: A committing tagged head with `head_last_i`=1 in a passed slot frees that slot from the next cycle.
- R10: A result for a slot that is not pending is ignored: the slot keeps its state and `irq_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_start_i | input | 1 | Fetch enters a monitored trace and requests a slot |
| alloc_ok_o | output | 1 | A slot is granted this cycle |
| alloc_slot_o | output | 2 | Number of the granted slot |
| fetch_stall_o | output | 1 | No free slot; fetch must hold |
| vres_valid_i | input | 1 | Check result is valid |
| vres_slot_i | input | 2 | Slot the result belongs to |
| vres_pass_i | input | 1 | 1 = pass, 0 = fail |
| head_valid_i | input | 1 | An instruction requests commit |
| head_tag_i | input | 1 | Head instruction carries a pending tag |
| head_slot_i | input | 2 | Slot of the head instruction |
| head_last_i | input | 1 | Head is the last instruction of its trace |
| commit_o | output | 1 | Head is released |
| stall_o | output | 1 | Head is held |
| flush_i | input | 1 | Request to clear a failed slot |
| flush_slot_i | input | 2 | Slot to clear |
| irq_o | output | 1 | Integrity fail interrupt, one-cycle pulse |

## Verification
`commit_o`, `stall_o`, `alloc_ok_o`, `alloc_slot_o` and `fetch_stall_o` are due in the same cycle as the inputs that cause them, including a result that lands together with the head. Slot state changes (allocation, pass, fail, release, flush) show up from the next cycle, and `irq_o` rises exactly one cycle after a fail. The bench drives inputs on the falling edge, compares the same-cycle outputs against its slot model 1 ns later, and advances the model at the rising edge. A registered output is therefore compared in the cycle after its cause.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_PEND = 2'd1,
    SLOT_PASS = 2'd2,
    SLOT_FAIL = 2'd3
  } slot_st_e;
endpackage

// File: rtl/tcg_alloc.sv
module tcg_alloc #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] free_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/tcg_slot.sv
module tcg_slot
  import tcg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     alloc_i,
  input  logic     vres_hit_i,
  input  logic     vres_pass_i,
  input  logic     release_i,
  input  logic     flush_i,
  output slot_st_e state_o,
  output slot_st_e eff_o,
  output logic     fail_o
);
  slot_st_e state_q, state_d;

  // a result for a pending slot acts in its own cycle
  always_comb begin
    eff_o = state_q;
    if (state_q == SLOT_PEND && vres_hit_i)
      eff_o = vres_pass_i ? SLOT_PASS : SLOT_FAIL;
  end

  assign fail_o = (state_q == SLOT_PEND) && vres_hit_i && !vres_pass_i;

  always_comb begin
    state_d = eff_o;
    if (alloc_i && state_q == SLOT_FREE)      state_d = SLOT_PEND;
    else if (release_i && eff_o == SLOT_PASS) state_d = SLOT_FREE;
    else if (flush_i && state_q == SLOT_FAIL) state_d = SLOT_FREE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SLOT_FREE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_alloc_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && state_q == SLOT_FREE) |=> state_q == SLOT_PEND);
  assert_fail_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SLOT_FAIL && !flush_i) |=> state_q == SLOT_FAIL);
  assert_idle_ignores_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SLOT_FREE && !alloc_i) |=> state_q == SLOT_FREE);
  assert_flush_frees_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SLOT_FAIL && flush_i) |=> state_q == SLOT_FREE);
endmodule

// File: rtl/trace_commit_gate.sv
module trace_commit_gate
  import tcg_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trace_start_i,
  output logic              alloc_ok_o,
  output logic [SLOT_W-1:0] alloc_slot_o,
  output logic              fetch_stall_o,
  input  logic              vres_valid_i,
  input  logic [SLOT_W-1:0] vres_slot_i,
  input  logic              vres_pass_i,
  input  logic              head_valid_i,
  input  logic              head_tag_i,
  input  logic [SLOT_W-1:0] head_slot_i,
  input  logic              head_last_i,
  output logic              commit_o,
  output logic              stall_o,
  input  logic              flush_i,
  input  logic [SLOT_W-1:0] flush_slot_i,
  output logic              irq_o
);
  logic [NUM_SLOTS-1:0] free_v, alloc_v, hit_v, rel_v, flush_v, fail_v;
  slot_st_e             cur_st [NUM_SLOTS];
  slot_st_e             eff_st [NUM_SLOTS];
  logic                 any_free, head_pass, irq_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign free_v[g]  = (cur_st[g] == SLOT_FREE);
    assign alloc_v[g] = alloc_ok_o && (alloc_slot_o == SLOT_W'(g));
    assign hit_v[g]   = vres_valid_i && (vres_slot_i == SLOT_W'(g));
    assign rel_v[g]   = commit_o && head_tag_i && head_last_i && (head_slot_i == SLOT_W'(g));
    assign flush_v[g] = flush_i && (flush_slot_i == SLOT_W'(g));

    tcg_slot i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc_v[g]),
      .vres_hit_i  (hit_v[g]),
      .vres_pass_i (vres_pass_i),
      .release_i   (rel_v[g]),
      .flush_i     (flush_v[g]),
      .state_o     (cur_st[g]),
      .eff_o       (eff_st[g]),
      .fail_o      (fail_v[g])
    );
  end

  tcg_alloc #(.N(NUM_SLOTS), .W(SLOT_W)) i_alloc (
    .free_i (free_v),
    .any_o  (any_free),
    .idx_o  (alloc_slot_o)
  );

  assign alloc_ok_o    = trace_start_i && any_free;
  assign fetch_stall_o = trace_start_i && !any_free;

  assign head_pass = (eff_st[head_slot_i] == SLOT_PASS);
  assign commit_o  = head_valid_i && (!head_tag_i || head_pass);
  assign stall_o   = head_valid_i && !commit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |fail_v;
  end
  assign irq_o = irq_q;

  assert_untagged_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_valid_i && !head_tag_i) |-> commit_o);
  assert_pending_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_valid_i && head_tag_i && cur_st[head_slot_i] != SLOT_PASS && !vres_valid_i) |-> stall_o);
  assert_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(vres_valid_i && !vres_pass_i));
  assert_full_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |-> (!alloc_ok_o && $countones(free_v) == 0));
endmodule

// File: tb/test_trace_commit_gate.sv
`timescale 1ns/1ps
module test_trace_commit_gate;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic trace_start = 0, vres_valid = 0, vres_pass = 0, head_valid = 0;
  logic head_tag = 0, head_last = 0, flush = 0;
  logic [1:0] vres_slot = 0, head_slot = 0, flush_slot = 0;
  logic alloc_ok, fetch_stall, commit, stall, irq;
  logic [1:0] alloc_slot;

  int tests = 0, fails = 0;
  int st [4];          // 0 free, 1 pend, 2 pass, 3 fail
  bit irq_exp = 0;

  always #4 clk = ~clk;

  trace_commit_gate i_trace_commit_gate (
    .clk_i(clk), .rst_ni(rst_ni), .trace_start_i(trace_start),
    .alloc_ok_o(alloc_ok), .alloc_slot_o(alloc_slot), .fetch_stall_o(fetch_stall),
    .vres_valid_i(vres_valid), .vres_slot_i(vres_slot), .vres_pass_i(vres_pass),
    .head_valid_i(head_valid), .head_tag_i(head_tag), .head_slot_i(head_slot),
    .head_last_i(head_last), .commit_o(commit), .stall_o(stall),
    .flush_i(flush), .flush_slot_i(flush_slot), .irq_o(irq));

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // one cycle: compare at negedge+1, advance model at posedge
  task automatic cyc();
    int eff [4];
    int nxt [4];
    int first_free;
    bit c_exp, fail_now;
    string creq;
    #1;
    first_free = -1;
    for (int s = 3; s >= 0; s--) if (st[s] == 0) first_free = s;
    fail_now = 0;
    for (int s = 0; s < 4; s++) begin
      eff[s] = st[s];
      if (vres_valid && vres_slot == 2'(s) && st[s] == 1) begin
        eff[s] = vres_pass ? 2 : 3;
        if (!vres_pass) fail_now = 1;
      end
    end
    c_exp = head_valid && (!head_tag || eff[head_slot] == 2);
    creq = !head_tag ? "R2" : ((eff[head_slot] == 2) ? "R4" : "R3");
    chk(creq, "commit", commit, c_exp);
    chk(creq, "stall", stall, head_valid && !c_exp);
    chk(first_free < 0 ? "R8" : "R7", "alloc_ok", alloc_ok, trace_start && first_free >= 0);
    chk("R8", "fetch_stall", fetch_stall, trace_start && first_free < 0);
    if (trace_start && first_free >= 0) chk("R7", "alloc_slot", alloc_slot, first_free);
    chk("R5", "irq", irq, irq_exp);
    for (int s = 0; s < 4; s++) begin
      nxt[s] = eff[s];
      if (trace_start && first_free == s) nxt[s] = 1;
      else if (c_exp && head_tag && head_last && head_slot == 2'(s) && eff[s] == 2) nxt[s] = 0;
      else if (flush && flush_slot == 2'(s) && st[s] == 3) nxt[s] = 0;
    end
    @(posedge clk);
    for (int s = 0; s < 4; s++) st[s] = nxt[s];
    irq_exp = fail_now;
    @(negedge clk);
  endtask

  task automatic idle();
    trace_start = 0; vres_valid = 0; vres_pass = 0; head_valid = 0;
    head_tag = 0; head_last = 0; flush = 0;
  endtask

  task automatic head(input bit tag, input int slot, input bit last);
    head_valid = 1; head_tag = tag; head_slot = 2'(slot); head_last = last;
  endtask

  task automatic vres(input int slot, input bit pass);
    vres_valid = 1; vres_slot = 2'(slot); vres_pass = pass;
  endtask

  initial begin
    for (int s = 0; s < 4; s++) st[s] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1: reset state
    chk("R1", "commit", commit, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "fetch_stall", fetch_stall, 0);
    trace_start = 1; #1;
    chk("R1", "alloc_ok", alloc_ok, 1);
    trace_start = 0;
    cyc();
    // R2: untagged head
    head(0, 3, 0); cyc(); idle();
    // R7: fill all four slots
    repeat (4) begin trace_start = 1; cyc(); end
    // R8: no free slot
    trace_start = 1; cyc(); idle();
    // R3: pending head held
    head(1, 1, 0); cyc();
    // R4: pass in same cycle as head
    vres(1, 1); cyc(); vres_valid = 0;
    // R9: last instruction frees slot 1, then reuse
    head(1, 1, 1); cyc(); idle();
    trace_start = 1; cyc(); idle();
    // R5: fail slot 2, irq next cycle, head blocked
    vres(2, 0); head(1, 2, 0); cyc(); idle();
    head(1, 2, 0); cyc();
    // R10: result for failed slot ignored
    vres(2, 1); cyc(); cyc(); idle();
    // R6: flush of pending slot 0 ignored, flush of failed slot 2 frees it
    flush = 1; flush_slot = 0; cyc();
    flush_slot = 2; cyc(); idle();
    trace_start = 1; cyc(); idle();
    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      trace_start = 1'($urandom_range(0, 2) == 0);
      vres_valid  = 1'($urandom_range(0, 2) == 0);
      vres_slot   = 2'($urandom_range(0, 3));
      vres_pass   = 1'($urandom_range(0, 3) != 0);
      head_valid  = 1'($urandom_range(0, 1));
      head_tag    = 1'($urandom_range(0, 3) != 0);
      head_slot   = 2'($urandom_range(0, 3));
      head_last   = 1'($urandom_range(0, 2) == 0);
      flush       = 1'($urandom_range(0, 3) == 0);
      flush_slot  = 2'($urandom_range(0, 3));
      cyc();
    end
    idle(); cyc();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule